// File: doc/BRIEF.md
# Signature-based episode recorder

This block sits beside one core and splits its execution into episodes. Within an episode, no remote coherence traffic touches lines that the core has used. The recorder keeps two Bloom-filter signatures over the cache-line addresses of the current episode:

- a read signature, filled by local loads;
- a write signature, filled by local stores.

Each incoming remote coherence request is tested against these signatures. When a request conflicts, the episode closes. The recorder then emits a log record holding the number of instructions retired in the episode and the episode's timestamp. It also clears both signatures and advances its scalar timestamp.

The timestamp is presented continuously so that it can be attached to every outgoing coherence reply. Timestamps arriving on incoming replies are tracked during the episode. This keeps the episodes of all cores in one total order that a sequential replayer can follow.

Top module: `episode_recorder`

## Requirements
- R1: After reset the timestamp output is 0, no log record is pending, and no remote request conflicts.
- R2: A line address is hashed to two bit positions per signature.
  - The first position is the XOR fold of the address: bit k of the index is the XOR of every address bit i with i mod W = k, where W is log2 of the signature size.
  - The second position is the same fold taken over the bit-reversed address.
  - A load sets both positions in the 1024-bit read signature. A store sets both positions in the 256-bit write signature.
  - A signature hits only when both of its positions are set.
- R3: A remote read (rq_write = 0) conflicts exactly when it hits the write signature. Lines that were only loaded do not cause a conflict.
- R4: A remote write or invalidation (rq_write = 1) conflicts when it hits either signature.
- R5: conflict_o is combinational in the cycle of the request. It is judged against the signature state held before that cycle's local accesses.
- R6: A conflict clears both signatures, so a repeated request to the same line in a later cycle no longer conflicts.
- R7: One cycle after a conflict edge, log_valid pulses for one cycle. log_len then holds the number of retire pulses since the previous episode end, and log_ts holds the timestamp the episode ran under.
- R8: On a conflict, the new timestamp is one more than the larger of the local timestamp and the largest reply timestamp seen during the episode. A reply arriving in the conflict cycle counts toward that maximum.
- R9: An episode with zero retired instructions produces no log record, but its conflict still advances the timestamp.
- R10: A load, store or retire pulse in the same cycle as a conflict belongs to the new episode.
- R11: Between conflicts the timestamp output does not change, whatever reply timestamps arrive.
- R12: The episode length saturates at 2^LEN_W - 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire | input | 1 | One instruction retired this cycle |
| ld_valid | input | 1 | Local load this cycle |
| ld_line | input | ADDR_W | Line address of the local load |
| st_valid | input | 1 | Local store this cycle |
| st_line | input | ADDR_W | Line address of the local store |
| rq_valid | input | 1 | Remote coherence request this cycle |
| rq_write | input | 1 | 1 = remote write or invalidation, 0 = remote read |
| rq_line | input | ADDR_W | Line address of the remote request |
| rp_valid | input | 1 | Coherence reply received this cycle |
| rp_ts | input | TS_W | Timestamp carried by the received reply |
| conflict_o | output | 1 | Remote request conflicts with the current episode |
| ts_o | output | TS_W | Timestamp to attach to outgoing replies |
| log_valid | output | 1 | Log record valid |
| log_len | output | LEN_W | Instructions retired in the closed episode |
| log_ts | output | TS_W | Timestamp of the closed episode |

## Verification
Three events can coincide with a conflicting remote request: a local access, a retire pulse and an arriving reply timestamp.

The bench places a load and a retire pulse in the very cycle a remote write ends an episode. It then confirms three things:
- the closed record omits that retire;
- a later remote write to the loaded line conflicts;
- the following record counts exactly one instruction.

In a separate scenario, the bench delivers a reply timestamp in the conflict cycle and judges the new timestamp against the requirement's maximum-plus-one rule. A reference model of both signatures supplies the expected conflict on every cycle.

// File: rtl/episode_recorder.sv
module episode_recorder #(
  parameter int ADDR_W    = 32,
  parameter int RSIG_BITS = 1024,
  parameter int WSIG_BITS = 256,
  parameter int TS_W      = 32,
  parameter int LEN_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              retire,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_line,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_line,
  input  logic              rq_valid,
  input  logic              rq_write,
  input  logic [ADDR_W-1:0] rq_line,
  input  logic              rp_valid,
  input  logic [TS_W-1:0]   rp_ts,
  output logic              conflict_o,
  output logic [TS_W-1:0]   ts_o,
  output logic              log_valid,
  output logic [LEN_W-1:0]  log_len,
  output logic [TS_W-1:0]   log_ts
);
  localparam int RI = $clog2(RSIG_BITS);
  localparam int WI = $clog2(WSIG_BITS);

  function automatic logic [15:0] fold(input logic [ADDR_W-1:0] a, input int w, input logic rev);
    logic [15:0] h;
    h = '0;
    for (int i = 0; i < ADDR_W; i++)
      h[i % w] = h[i % w] ^ (rev ? a[ADDR_W-1-i] : a[i]);
    return h;
  endfunction

  function automatic logic [RSIG_BITS-1:0] rmask(input logic [ADDR_W-1:0] a);
    logic [15:0] p0, p1;
    logic [RSIG_BITS-1:0] m;
    p0 = fold(a, RI, 1'b0);
    p1 = fold(a, RI, 1'b1);
    m = '0;
    m[p0[RI-1:0]] = 1'b1;
    m[p1[RI-1:0]] = 1'b1;
    return m;
  endfunction

  function automatic logic [WSIG_BITS-1:0] wmask(input logic [ADDR_W-1:0] a);
    logic [15:0] p0, p1;
    logic [WSIG_BITS-1:0] m;
    p0 = fold(a, WI, 1'b0);
    p1 = fold(a, WI, 1'b1);
    m = '0;
    m[p0[WI-1:0]] = 1'b1;
    m[p1[WI-1:0]] = 1'b1;
    return m;
  endfunction

  logic [RSIG_BITS-1:0] rsig, rq_rm, ld_rm;
  logic [WSIG_BITS-1:0] wsig, rq_wm, st_wm;
  logic [TS_W-1:0]      ts, mx, rx_max, base;
  logic [LEN_W-1:0]     ep_len, len_inc;
  logic                 hit_r, hit_w, conflict;

  always_comb begin
    rq_rm = rmask(rq_line);
    rq_wm = wmask(rq_line);
    ld_rm = rmask(ld_line);
    st_wm = wmask(st_line);
  end

  assign hit_r    = (rsig & rq_rm) == rq_rm;
  assign hit_w    = (wsig & rq_wm) == rq_wm;
  assign conflict = rq_valid && (hit_w || (rq_write && hit_r));
  assign rx_max   = (rp_valid && rp_ts > mx) ? rp_ts : mx;
  assign base     = (ts > rx_max) ? ts : rx_max;
  assign len_inc  = (retire && ep_len != {LEN_W{1'b1}}) ? ep_len + LEN_W'(1) : ep_len;

  assign conflict_o = conflict;
  assign ts_o       = ts;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsig      <= '0;
      wsig      <= '0;
      ts        <= '0;
      mx        <= '0;
      ep_len    <= '0;
      log_valid <= 1'b0;
      log_len   <= '0;
      log_ts    <= '0;
    end else begin
      log_valid <= conflict && (ep_len != '0);
      if (conflict) begin
        log_len <= ep_len;
        log_ts  <= ts;
        ts      <= base + TS_W'(1);
        mx      <= '0;
        ep_len  <= retire ? LEN_W'(1) : '0;
        rsig    <= ld_valid ? ld_rm : '0;
        wsig    <= st_valid ? st_wm : '0;
      end else begin
        mx     <= rx_max;
        ep_len <= len_inc;
        if (ld_valid) rsig <= rsig | ld_rm;
        if (st_valid) wsig <= wsig | st_wm;
      end
    end
  end

  // R5
  conflict_needs_rq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conflict_o |-> rq_valid);

  // R7
  log_after_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    log_valid |-> ($past(conflict_o) && log_len != '0));

  // R8
  ts_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conflict_o |=> (ts_o > $past(ts_o)));

  // R11
  ts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !conflict_o |=> $stable(ts_o));

  // R6
  sig_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conflict_o && !ld_valid && !st_valid) |=> (rsig == '0 && wsig == '0));
endmodule

// File: tb/sim_episode_recorder.sv
module sim_episode_recorder;
  localparam int AW = 32, RSB = 1024, WSB = 256, TW = 32, LW = 6;

  logic clk = 0, rst_n = 0;
  logic retire = 0, ld_valid = 0, st_valid = 0, rq_valid = 0, rq_write = 0, rp_valid = 0;
  logic [AW-1:0] ld_line = 0, st_line = 0, rq_line = 0;
  logic [TW-1:0] rp_ts = 0;
  logic conflict_o, log_valid;
  logic [TW-1:0] ts_o, log_ts;
  logic [LW-1:0] log_len;

  always #4 clk = ~clk;

  episode_recorder #(.ADDR_W(AW), .RSIG_BITS(RSB), .WSIG_BITS(WSB), .TS_W(TW), .LEN_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .retire(retire),
    .ld_valid(ld_valid), .ld_line(ld_line), .st_valid(st_valid), .st_line(st_line),
    .rq_valid(rq_valid), .rq_write(rq_write), .rq_line(rq_line),
    .rp_valid(rp_valid), .rp_ts(rp_ts),
    .conflict_o(conflict_o), .ts_o(ts_o),
    .log_valid(log_valid), .log_len(log_len), .log_ts(log_ts));

  int total = 0, bad = 0;
  bit done = 0;

  bit m_rs [RSB];
  bit m_ws [WSB];
  longint m_ts = 0, m_mx = 0, m_len = 0;

  logic b_ret, b_ld, b_st, b_rq, b_rqw, b_rp;
  logic [AW-1:0] b_lda, b_sta, b_rqa;
  logic [TW-1:0] b_rpts;

  localparam logic [AW-1:0] LA = 32'h0000_1240;
  localparam logic [AW-1:0] LB = 32'h0abc_0010;
  localparam logic [AW-1:0] LC = 32'h7700_0f08;

  function automatic int hpos(logic [AW-1:0] a, int w, bit rev);
    int r = 0;
    for (int k = 0; k < w; k++) begin
      bit x = 0;
      for (int i = k; i < AW; i += w) x ^= rev ? a[AW-1-i] : a[i];
      r |= int'(x) << k;
    end
    return r;
  endfunction

  function automatic bit rs_hit(logic [AW-1:0] a);
    return m_rs[hpos(a, 10, 0)] && m_rs[hpos(a, 10, 1)];
  endfunction

  function automatic bit ws_hit(logic [AW-1:0] a);
    return m_ws[hpos(a, 8, 0)] && m_ws[hpos(a, 8, 1)];
  endfunction

  task automatic chk(string tag, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic clr();
    b_ret = 0; b_ld = 0; b_st = 0; b_rq = 0; b_rqw = 0; b_rp = 0;
    b_lda = 0; b_sta = 0; b_rqa = 0; b_rpts = 0;
  endtask

  task automatic tick(string tag);
    bit hit, exp_log;
    longint mxe, exp_len, exp_lts, bs;
    @(negedge clk);
    retire = b_ret; ld_valid = b_ld; ld_line = b_lda; st_valid = b_st; st_line = b_sta;
    rq_valid = b_rq; rq_write = b_rqw; rq_line = b_rqa; rp_valid = b_rp; rp_ts = b_rpts;
    hit = b_rq && (ws_hit(b_rqa) || (b_rqw && rs_hit(b_rqa)));
    #1 chk(tag, "conflict_o", conflict_o, hit);
    @(posedge clk);
    mxe = (b_rp && b_rpts > m_mx) ? b_rpts : m_mx;
    exp_log = 0; exp_len = 0; exp_lts = 0;
    if (hit) begin
      exp_log = (m_len != 0); exp_len = m_len; exp_lts = m_ts;
      bs = (m_ts > mxe) ? m_ts : mxe;
      m_ts = bs + 1; m_mx = 0; m_len = b_ret ? 1 : 0;
      foreach (m_rs[i]) m_rs[i] = 0;
      foreach (m_ws[i]) m_ws[i] = 0;
    end else begin
      m_mx = mxe;
      if (b_ret && m_len < (1 << LW) - 1) m_len++;
    end
    if (b_ld) begin m_rs[hpos(b_lda, 10, 0)] = 1; m_rs[hpos(b_lda, 10, 1)] = 1; end
    if (b_st) begin m_ws[hpos(b_sta, 8, 0)] = 1; m_ws[hpos(b_sta, 8, 1)] = 1; end
    #1;
    chk(tag, "log_valid", log_valid, exp_log);
    if (exp_log) begin
      chk(tag, "log_len", log_len, exp_len);
      chk(tag, "log_ts", log_ts, exp_lts);
    end
    chk(tag, "ts_o", ts_o, m_ts);
    clr();
  endtask

  task automatic t_reset();
    clr();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1", "ts_o", ts_o, 0);
    chk("R1", "log_valid", log_valid, 0);
    b_rq = 1; b_rqw = 1; b_rqa = LC; tick("R1");
  endtask

  task automatic t_read_rules();
    b_ld = 1; b_lda = LA; b_ret = 0; tick("R2");
    b_rq = 1; b_rqw = 0; b_rqa = LA; tick("R3");
    chk("R3", "read to loaded-only line", conflict_o, 0);
    b_st = 1; b_sta = LA; tick("R2");
    b_rq = 1; b_rqw = 0; b_rqa = LA; tick("R9");
    chk("R9", "ts after empty episode", ts_o, 1);
  endtask

  task automatic t_write_rules();
    b_ld = 1; b_lda = LB; tick("R2");
    b_rq = 1; b_rqw = 1; b_rqa = LB; tick("R4");
    chk("R4", "ts after write hit on read sig", ts_o, 2);
  endtask

  task automatic t_clear_and_log();
    b_st = 1; b_sta = LA; tick("R6");
    for (int i = 0; i < 3; i++) begin b_ret = 1; tick("R7"); end
    b_rq = 1; b_rqw = 1; b_rqa = LA; tick("R7");
    chk("R7", "log_len", log_len, 3);
    chk("R7", "log_ts", log_ts, 2);
    b_rq = 1; b_rqw = 1; b_rqa = LA; tick("R6");
    chk("R6", "repeat request after clear", conflict_o, 0);
  endtask

  task automatic t_timestamps();
    b_rp = 1; b_rpts = 40; tick("R8");
    b_st = 1; b_sta = LB; tick("R8");
    b_rq = 1; b_rqw = 0; b_rqa = LB; b_rp = 1; b_rpts = 50; tick("R8");
    chk("R8", "ts with same-cycle reply", ts_o, 51);
    b_rp = 1; b_rpts = 10; b_st = 1; b_sta = LC; tick("R8");
    b_rq = 1; b_rqw = 1; b_rqa = LC; tick("R8");
    chk("R8", "ts with smaller reply", ts_o, 52);
  endtask

  task automatic t_same_cycle();
    b_st = 1; b_sta = LB; tick("R10");
    b_rq = 1; b_rqw = 1; b_rqa = LB; b_ld = 1; b_lda = LA; b_ret = 1; tick("R10");
    chk("R10", "no record for empty episode", log_valid, 0);
    b_rq = 1; b_rqw = 1; b_rqa = LA; tick("R10");
    chk("R10", "log_len of new episode", log_len, 1);
    chk("R10", "log_ts", log_ts, 53);
  endtask

  task automatic t_hold();
    for (int i = 0; i < 4; i++) begin b_rp = 1; b_rpts = TW'(900 + i); tick("R11"); end
    chk("R11", "ts_o held", ts_o, 54);
    b_st = 1; b_sta = LC; tick("R11");
    b_rq = 1; b_rqw = 0; b_rqa = LC; tick("R11");
    chk("R11", "ts after replies", ts_o, 904);
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 70; i++) begin b_ret = 1; tick("R12"); end
    b_st = 1; b_sta = LA; tick("R12");
    b_rq = 1; b_rqw = 1; b_rqa = LA; tick("R12");
    chk("R12", "saturated log_len", log_len, 63);
  endtask

  initial begin
    foreach (m_rs[i]) m_rs[i] = 0;
    foreach (m_ws[i]) m_ws[i] = 0;
    t_reset();
    t_read_rules();
    t_write_rules();
    t_clear_and_log();
    t_timestamps();
    t_same_cycle();
    t_hold();
    t_saturate();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog R1: got hang expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule